// File: doc/BRIEF.md
# SMBus Descriptor Ring Controller

This block is the register front end and ring manager of a descriptor-driven SMBus master. Software places 16-byte transaction descriptors in a ring in system memory. It programs the ring base and the number of entries, and then moves a head pointer forward and sets a run bit. The controller walks the ring from its own tail pointer up to the software head. For each entry it reads the descriptor as four 32-bit words, hands it to the bus transaction sequencer, and waits for that transfer to finish. It then writes the result bytes back into the same descriptor and steps the tail. Interrupt and error-interrupt flags are raised per entry and cleared by writing ones.

The ring walker is a four-state machine. ST_IDLE moves to ST_FETCH when the run bit is set and the tail differs from the head. ST_FETCH reads words 0 to 3 and moves to ST_EXEC after word 3, or to ST_WBACK on a kill. ST_EXEC waits for the sequencer and moves to ST_WBACK on completion or on a kill. ST_WBACK makes one write and returns to ST_IDLE. A soft reset forces ST_IDLE from any state. Descriptor word 0 carries, from the low byte up: target address with R/W, write length or command, read length, and control. Word 1 carries, from the low byte up: status, retry, received count and transmitted count. Words 2 and 3 are the data pointer.

Top module: `smb_ring_ctrl`

## Requirements
- R1: After reset the status register (offset 0x10C) reads 0, control (0x108) reads 0, irq is low, and speed_sel is 2'b01.
- R2: The ring base low and high words (0x100, 0x104), ring size (0x110, low 8 bits), retry policy (0x114) and bus timing (0x300) read back as written. General control (0x000) always reads 0. speed_sel equals bus timing bits 31:30.
- R3: When control bit 0 (run) is 1 and the tail differs from the head (control bits 23:16), the block reads words 0 to 3 at base + 16 x tail + 4 x k. When run is 0, or the tail equals the head, no fetch happens and status bit 0 (busy) stays 0.
- R4: After word 3 is fetched, seq_start pulses for one cycle, with seq_desc holding words 3..0 from high bits to low bits.
- R5: At the end of a descriptor the block makes exactly one write, to base + 16 x tail + 4. The data is {transmitted, received, fetched retry byte, status} from the high byte to the low byte.
- R6: The tail (status bits 23:16) advances after each write-back and wraps from the ring-size value to 0.
- R7: At write-back, status bit 5 is set if descriptor control bit 6 is 1. Status bit 4 is set if status bit 0 of the written result is 0 and control bit 4 is 1. irq is the OR of status bits 5 and 4.
- R8: Writing 1 to status bit 5 or bit 4 clears that bit, and writing 0 leaves it unchanged. A clear that arrives in the cycle the bit is being set loses, and the bit ends up set.
- R9: Writing general control bit 3 (kill) clears run. During ST_FETCH or ST_EXEC it also aborts the entry, with seq_abort pulsing in ST_EXEC. The entry is written back as {0, 0, retry, 0}, the tail advances, and the entry counts as a failure. In ST_IDLE a kill only clears run.
- R10: Writing general control bit 6 (soft reset) clears the tail, the head, run, busy and both interrupt bits in the next cycle, with no write-back. It leaves control bit 4 unchanged.
- R11: Writing general control bit 2 pulses tgt_rst high for the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 64 | Descriptor word read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Write-back strobe |
| mem_wr_addr | output | 64 | Write-back address |
| mem_wr_data | output | 32 | Write-back data |
| seq_start | output | 1 | Descriptor handed to sequencer |
| seq_desc | output | 128 | Fetched descriptor |
| seq_abort | output | 1 | Abort of the running transfer |
| seq_done | input | 1 | Sequencer finished |
| seq_status | input | 8 | Result status byte, bit 0 = success |
| seq_rx | input | 8 | Bytes received |
| seq_tx | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |
| speed_sel | output | 2 | Bus speed code |
| tgt_rst | output | 1 | Target reset pulse |

## Verification
The write-back in ST_WBACK sets the interrupt bit in the same cycle that software may write ones to clear it. The bench watches for mem_wr_en at a falling edge and drives a clear of status bit 5 inside that cycle. It then reads status and expects bit 5 to be set, and expects a later clear to take effect. A kill is also driven in the cycle the sequencer is running. The bench judges it by the abort pulse seen in that same cycle and by the written-back bytes.

// File: rtl/smb_ring_pkg.sv
package smb_ring_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_WBACK} ring_state_t;

    localparam logic [11:0] OFS_GCTRL   = 12'h000;
    localparam logic [11:0] OFS_BASE_LO = 12'h100;
    localparam logic [11:0] OFS_BASE_HI = 12'h104;
    localparam logic [11:0] OFS_MCTRL   = 12'h108;
    localparam logic [11:0] OFS_MSTS    = 12'h10C;
    localparam logic [11:0] OFS_SIZE    = 12'h110;
    localparam logic [11:0] OFS_RETRY   = 12'h114;
    localparam logic [11:0] OFS_TIMING  = 12'h300;

    localparam int BIT_TGT_RST = 2;
    localparam int BIT_KILL    = 3;
    localparam int BIT_SRST    = 6;
    localparam int BIT_RUN     = 0;
    localparam int BIT_EIE     = 4;
    localparam int BIT_BUSY    = 0;
    localparam int BIT_MEIS    = 4;
    localparam int BIT_MIS     = 5;
    localparam int PTR_LSB     = 16;
    localparam int DESC_INT_BIT = 30;

    localparam logic [31:0] TIMING_RESET = 32'h4000_0000;
endpackage

// File: rtl/smb_ring_regs.sv
module smb_ring_regs
    import smb_ring_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic [PTR_W-1:0]  tail,
    input  logic              cpl_int,
    input  logic              cpl_fail,
    output logic              kill_req,
    output logic              srst_req,
    output logic              tgt_rst,
    output logic [ADDR_W-1:0] base,
    output logic              start,
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  size,
    output logic              mis,
    output logic              meis,
    output logic              irq,
    output logic [1:0]        speed_sel
);
    logic        eie;
    logic [31:0] retry_q;
    logic [31:0] timing_q;
    logic        wr_g, wr_ctl, wr_sts;

    always_comb begin
        wr_g   = reg_wr && (reg_addr == OFS_GCTRL);
        wr_ctl = reg_wr && (reg_addr == OFS_MCTRL);
        wr_sts = reg_wr && (reg_addr == OFS_MSTS);
    end

    assign kill_req  = wr_g && reg_wdata[BIT_KILL];
    assign srst_req  = wr_g && reg_wdata[BIT_SRST];
    assign tgt_rst   = wr_g && reg_wdata[BIT_TGT_RST];
    assign irq       = mis | meis;
    assign speed_sel = timing_q[31:30];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base     <= '0;
            start    <= 1'b0;
            eie      <= 1'b0;
            head     <= '0;
            size     <= '0;
            retry_q  <= '0;
            timing_q <= TIMING_RESET;
            mis      <= 1'b0;
            meis     <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_BASE_LO) base[31:0] <= reg_wdata;
            if (reg_wr && reg_addr == OFS_BASE_HI) base[ADDR_W-1:32] <= reg_wdata[ADDR_W-33:0];
            if (reg_wr && reg_addr == OFS_SIZE)    size <= reg_wdata[PTR_W-1:0];
            if (reg_wr && reg_addr == OFS_RETRY)   retry_q <= reg_wdata;
            if (reg_wr && reg_addr == OFS_TIMING)  timing_q <= reg_wdata;
            if (wr_ctl) begin
                start <= reg_wdata[BIT_RUN];
                eie   <= reg_wdata[BIT_EIE];
                head  <= reg_wdata[PTR_LSB +: PTR_W];
            end
            if (kill_req) start <= 1'b0;
            if (srst_req) begin
                start <= 1'b0;
                head  <= '0;
                mis   <= 1'b0;
                meis  <= 1'b0;
            end else begin
                mis  <= cpl_int | (mis & ~(wr_sts & reg_wdata[BIT_MIS]));
                meis <= (cpl_fail & eie) | (meis & ~(wr_sts & reg_wdata[BIT_MEIS]));
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE_LO: reg_rdata = base[31:0];
            OFS_BASE_HI: reg_rdata = 32'(base[ADDR_W-1:32]);
            OFS_MCTRL: begin
                reg_rdata[BIT_RUN] = start;
                reg_rdata[BIT_EIE] = eie;
                reg_rdata[PTR_LSB +: PTR_W] = head;
            end
            OFS_MSTS: begin
                reg_rdata[BIT_BUSY] = busy;
                reg_rdata[BIT_MEIS] = meis;
                reg_rdata[BIT_MIS]  = mis;
                reg_rdata[PTR_LSB +: PTR_W] = tail;
            end
            OFS_SIZE:   reg_rdata = 32'(size);
            OFS_RETRY:  reg_rdata = retry_q;
            OFS_TIMING: reg_rdata = timing_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smb_ring_fsm.sv
module smb_ring_fsm
    import smb_ring_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  head,
    input  logic [PTR_W-1:0]  size,
    input  logic [ADDR_W-1:0] base,
    input  logic              kill_req,
    input  logic              srst_req,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              seq_start,
    output logic [127:0]      seq_desc,
    output logic              seq_abort,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_rx,
    input  logic [7:0]        seq_tx,
    output logic              busy,
    output logic [PTR_W-1:0]  tail,
    output logic              cpl_int,
    output logic              cpl_fail
);
    localparam int DESC_BYTES = 16;
    localparam int WB_OFFSET  = 4;

    ring_state_t       state, state_nxt;
    logic [1:0]        word_idx;
    logic [127:0]      desc_q;
    logic [31:0]       wb_q;
    logic [ADDR_W-1:0] slot_addr;
    logic [PTR_W-1:0]  tail_nxt;
    logic [7:0]        retry_b;

    assign slot_addr = base + ADDR_W'(tail) * ADDR_W'(DESC_BYTES);
    assign tail_nxt  = (tail == size) ? '0 : tail + 1'b1;
    assign retry_b   = desc_q[47:40];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (srst_req) state <= ST_IDLE;
        else               state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start && tail != head) state_nxt = ST_FETCH;
            ST_FETCH: begin
                if (kill_req) state_nxt = ST_WBACK;
                else if (mem_rd_valid && word_idx == 2'd3) state_nxt = ST_EXEC;
            end
            ST_EXEC:  if (kill_req || seq_done) state_nxt = ST_WBACK;
            ST_WBACK: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        mem_rd_req  = (state == ST_FETCH);
        mem_rd_addr = slot_addr + ADDR_W'({word_idx, 2'b00});
        mem_wr_en   = (state == ST_WBACK);
        mem_wr_addr = slot_addr + ADDR_W'(WB_OFFSET);
        mem_wr_data = wb_q;
        seq_abort   = (state == ST_EXEC) && kill_req;
        seq_desc    = desc_q;
        cpl_int     = (state == ST_WBACK) && desc_q[DESC_INT_BIT];
        cpl_fail    = (state == ST_WBACK) && !wb_q[0];
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx  <= '0;
            desc_q    <= '0;
            wb_q      <= '0;
            tail      <= '0;
            seq_start <= 1'b0;
        end else begin
            seq_start <= 1'b0;
            if (srst_req) begin
                tail     <= '0;
                word_idx <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        word_idx <= '0;
                        desc_q   <= '0;
                    end
                    ST_FETCH: begin
                        if (kill_req) begin
                            wb_q <= {16'h0000, retry_b, 8'h00};
                        end else if (mem_rd_valid) begin
                            desc_q[32*word_idx +: 32] <= mem_rd_data;
                            word_idx <= word_idx + 2'd1;
                            if (word_idx == 2'd3) seq_start <= 1'b1;
                        end
                    end
                    ST_EXEC: begin
                        if (kill_req)      wb_q <= {16'h0000, retry_b, 8'h00};
                        else if (seq_done) wb_q <= {seq_tx, seq_rx, retry_b, seq_status};
                    end
                    ST_WBACK: tail <= tail_nxt;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_ring_ctrl.sv
module smb_ring_ctrl
    import smb_ring_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              seq_start,
    output logic [127:0]      seq_desc,
    output logic              seq_abort,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_rx,
    input  logic [7:0]        seq_tx,
    output logic              irq,
    output logic [1:0]        speed_sel,
    output logic              tgt_rst
);
    logic              busy, start, kill_req, srst_req;
    logic              cpl_int, cpl_fail, mis, meis;
    logic [PTR_W-1:0]  tail, head, size;
    logic [ADDR_W-1:0] base;

    smb_ring_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .tail(tail),
        .cpl_int(cpl_int), .cpl_fail(cpl_fail), .kill_req(kill_req),
        .srst_req(srst_req), .tgt_rst(tgt_rst), .base(base), .start(start),
        .head(head), .size(size), .mis(mis), .meis(meis), .irq(irq),
        .speed_sel(speed_sel)
    );

    smb_ring_fsm #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .head(head), .size(size),
        .base(base), .kill_req(kill_req), .srst_req(srst_req),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .seq_start(seq_start), .seq_desc(seq_desc),
        .seq_abort(seq_abort), .seq_done(seq_done), .seq_status(seq_status),
        .seq_rx(seq_rx), .seq_tx(seq_tx), .busy(busy), .tail(tail),
        .cpl_int(cpl_int), .cpl_fail(cpl_fail)
    );
endmodule

// File: rtl/smb_ring_chk.sv
module smb_ring_chk #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             start,
    input logic [PTR_W-1:0] head,
    input logic [PTR_W-1:0] tail,
    input logic [PTR_W-1:0] size,
    input logic             mem_wr_en,
    input logic             seq_start,
    input logic             cpl_int,
    input logic             srst_req,
    input logic             mis
);
    // R3: a ring walk begins only with run set and entries pending
    assert_fetch_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && ($past(tail) != $past(head))));

    // R6: the tail only steps by one with wrap at the ring size
    assert_tail_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((tail != $past(tail)) && !$past(srst_req)) |->
        (tail == (($past(tail) == $past(size)) ? PTR_W'(0) : PTR_W'($past(tail) + 1'b1))));

    // R5: exactly one write-back strobe per entry
    assert_single_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    // R4: hand-off is a single-cycle pulse
    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    // R8: the set from a completion beats any same-cycle clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_int && !srst_req) |=> mis);

    // R10: soft reset empties the walker
    assert_srst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (!busy && tail == '0 && !mis));
endmodule

bind smb_ring_ctrl smb_ring_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .head(head),
    .tail(tail), .size(size), .mem_wr_en(mem_wr_en), .seq_start(seq_start),
    .cpl_int(cpl_int), .srst_req(srst_req), .mis(mis)
);

// File: tb/smb_ring_ctrl_bench.sv
module smb_ring_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [63:0] BASE = 64'h0000_0002_0000_1000;
    localparam int NVEC = 6;
    // {word0, retry, expected word1, expected int bit, expected error bit}
    localparam logic [73:0] VEC [NVEC] = '{
        {32'h400204A1, 8'h13, 32'h04021301, 1'b1, 1'b0},
        {32'h00000350, 8'h00, 32'h03000008, 1'b0, 1'b1},
        {32'h4020016B, 8'h27, 32'h01202708, 1'b1, 1'b1},
        {32'h0801023C, 8'h05, 32'h02010501, 1'b0, 1'b0},
        {32'hC010107F, 8'h31, 32'h10103101, 1'b1, 1'b0},
        {32'h4400FF11, 8'h02, 32'hFF000208, 1'b1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_rd_req, mem_rd_valid, mem_wr_en;
    logic [63:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data, mem_wr_data;
    logic seq_start, seq_abort, seq_done;
    logic [127:0] seq_desc;
    logic [7:0] seq_status, seq_rx, seq_tx;
    logic irq, tgt_rst;
    logic [1:0] speed_sel;

    logic [31:0] mem_q [32];
    int wr_count = 0, start_count = 0, seq_lat = 3, cnt = 0;
    logic [63:0] last_wr_addr = '0, last_rd_addr = '0;
    logic [127:0] got_desc = '0;
    int compared = 0, mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_ring_ctrl u_smb_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .seq_start(seq_start), .seq_desc(seq_desc), .seq_abort(seq_abort),
        .seq_done(seq_done), .seq_status(seq_status), .seq_rx(seq_rx),
        .seq_tx(seq_tx), .irq(irq), .speed_sel(speed_sel), .tgt_rst(tgt_rst)
    );

    // memory model: reads answer in the same cycle
    always_comb begin
        mem_rd_valid = mem_rd_req;
        mem_rd_data  = mem_q[5'((mem_rd_addr - BASE) >> 2)];
    end

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem_q[5'((mem_wr_addr - BASE) >> 2)] <= mem_wr_data;
            last_wr_addr <= mem_wr_addr;
            wr_count <= wr_count + 1;
        end
        if (mem_rd_req) last_rd_addr <= mem_rd_addr;
    end

    // sequencer model: odd write length fails with status 0x08, else 0x01
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; seq_done <= 1'b0;
            seq_status <= '0; seq_rx <= '0; seq_tx <= '0;
        end else begin
            seq_done <= 1'b0;
            if (seq_abort) cnt <= 0;
            else if (seq_start) begin
                cnt <= seq_lat;
                got_desc <= seq_desc;
                start_count <= start_count + 1;
                seq_tx <= seq_desc[15:8];
                seq_rx <= seq_desc[23:16];
                seq_status <= seq_desc[8] ? 8'h08 : 8'h01;
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) seq_done <= 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_wb(input int n);
        while (wr_count < n) @(negedge clk);
    endtask

    task automatic put_desc(input int slot, input logic [31:0] w0, input logic [7:0] retry);
        mem_q[slot*4]   = w0;
        mem_q[slot*4+1] = {8'hEE, 8'hEE, retry, 8'hEE};
        mem_q[slot*4+2] = 32'hD000_0000 + slot;
        mem_q[slot*4+3] = 32'h0000_00C0 + slot;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int n;
        for (int k = 0; k < 32; k++) mem_q[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(12'h10C, rd); check("R1 status", rd, 32'h0);
        reg_read(12'h108, rd); check("R1 control", rd, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 speed", {30'b0, speed_sel}, 32'h1);

        // R2 register readback
        reg_write(12'h100, BASE[31:0]);
        reg_write(12'h104, BASE[63:32]);
        reg_write(12'h110, 32'h7);
        reg_write(12'h114, 32'hA5A5_0033);
        reg_write(12'h300, 32'h8000_0123);
        reg_read(12'h100, rd); check("R2 base lo", rd, BASE[31:0]);
        reg_read(12'h104, rd); check("R2 base hi", rd, BASE[63:32]);
        reg_read(12'h110, rd); check("R2 size", rd, 32'h7);
        reg_read(12'h114, rd); check("R2 retry", rd, 32'hA5A5_0033);
        reg_read(12'h300, rd); check("R2 timing", rd, 32'h8000_0123);
        check("R2 speed", {30'b0, speed_sel}, 32'h2);
        reg_read(12'h000, rd); check("R2 gctrl", rd, 32'h0);

        // table walk: one entry per step, error interrupt enabled
        for (int i = 0; i < NVEC; i++) begin
            put_desc(i, VEC[i][73:42], VEC[i][41:34]);
            n = wr_count;
            reg_write(12'h108, 32'h11 | (32'(i + 1) << 16));
            wait_wb(n + 1);
            check("R5 word1", mem_q[i*4+1], VEC[i][33:2]);
            check("R5 wb addr", last_wr_addr[31:0], BASE[31:0] + 32'(16*i + 4));
            check("R3 fetch addr", last_rd_addr[31:0], BASE[31:0] + 32'(16*i + 12));
            check("R4 desc w0", got_desc[31:0], VEC[i][73:42]);
            check("R4 desc w2", got_desc[95:64], 32'hD000_0000 + 32'(i));
            reg_read(12'h10C, rd);
            check("R6 tail", {8'h0, rd[23:16]}, 32'(i + 1));
            check("R7 int", {31'b0, rd[5]}, {31'b0, VEC[i][1]});
            check("R7 err", {31'b0, rd[4]}, {31'b0, VEC[i][0]});
            check("R7 irq", {31'b0, irq}, {31'b0, VEC[i][1] | VEC[i][0]});
            reg_write(12'h10C, 32'h20);
            reg_read(12'h10C, rd);
            check("R8 clear int keeps err", {30'b0, rd[5:4]}, {30'b0, 1'b0, VEC[i][0]});
            reg_write(12'h10C, 32'h10);
            check("R8 both clear irq", {31'b0, irq}, 32'h0);
        end

        // R3 run bit clear: nothing fetched
        n = wr_count;
        reg_write(12'h108, 32'h0007_0010);
        repeat (10) @(negedge clk);
        reg_read(12'h10C, rd);
        check("R3 no run busy/tail", rd, 32'h0006_0000);
        check("R3 no run writes", 32'(wr_count), 32'(n));

        // R6 wrap across slots 6, 7, 0
        put_desc(6, 32'h00000210, 8'h01);
        put_desc(7, 32'h00000420, 8'h02);
        put_desc(0, 32'h00000630, 8'h03);
        n = wr_count;
        reg_write(12'h108, 32'h0001_0011);
        wait_wb(n + 3);
        reg_read(12'h10C, rd);
        check("R6 wrap tail", rd, 32'h0001_0000);
        check("R6 wrap addr", last_wr_addr[31:0], BASE[31:0] + 32'h4);
        check("R5 slot7 word1", mem_q[29], 32'h04000201);

        // R8 set and clear in the same cycle
        put_desc(1, 32'h40000200, 8'h00);
        reg_write(12'h108, 32'h0002_0011);
        while (!mem_wr_en) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h10C; reg_wdata = 32'h20;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_read(12'h10C, rd);
        check("R8 set wins", {31'b0, rd[5]}, 32'h1);
        reg_write(12'h10C, 32'h20);
        check("R8 later clear", {31'b0, irq}, 32'h0);

        // R9 kill while running
        put_desc(2, 32'h40000200, 8'h5A);
        seq_lat = 300;
        n = start_count;
        reg_write(12'h108, 32'h0003_0011);
        while (start_count == n) @(negedge clk);
        n = wr_count;
        reg_wr = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h08;
        #1 check("R9 abort pulse", {31'b0, seq_abort}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b0;
        wait_wb(n + 1);
        check("R9 kill word1", mem_q[9], 32'h0000_5A00);
        reg_read(12'h108, rd);
        check("R9 run cleared", {31'b0, rd[0]}, 32'h0);
        reg_read(12'h10C, rd);
        check("R9 status", rd, 32'h0003_0030);
        reg_write(12'h10C, 32'h30);

        // R10 soft reset while running
        put_desc(3, 32'h40000200, 8'h00);
        n = start_count;
        reg_write(12'h108, 32'h0004_0011);
        while (start_count == n) @(negedge clk);
        n = wr_count;
        reg_write(12'h000, 32'h40);
        reg_read(12'h10C, rd);
        check("R10 status", rd, 32'h0);
        reg_read(12'h108, rd);
        check("R10 control", rd, 32'h10);
        repeat (320) @(negedge clk);
        check("R10 no writeback", 32'(wr_count), 32'(n));
        check("R10 irq", {31'b0, irq}, 32'h0);

        // R9 kill in idle only clears run
        seq_lat = 3;
        reg_write(12'h108, 32'h0000_0011);
        reg_write(12'h000, 32'h08);
        reg_read(12'h108, rd);
        check("R9 idle kill", rd, 32'h10);
        check("R9 idle no write", 32'(wr_count), 32'(n));

        // R11 target reset pulse
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h04;
        #1 check("R11 pulse", {31'b0, tgt_rst}, 32'h1);
        @(negedge clk);
        reg_wr = 1'b0;
        #1 check("R11 end", {31'b0, tgt_rst}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule